// File: doc/BRIEF.md
# Random Access Slot Sequencer

This block times one random-access attempt of a terminal against an access-slot grid. Access slots are 5120 chips long. The receiver marks the start of each received downlink access slot with a strobe. The uplink access slots run ahead of the downlink ones by a lead time, and that lead time depends on a timing-mode bit. The block derives the uplink boundaries from the strobe and from a chip-rate enable. It fires a preamble only on such a boundary. It then looks for an acquisition indicator at the one downlink slot start that falls a lead time after the preamble.

A positive indicator makes the block schedule the message part a fixed number of slots after the preamble. If the indicator is negative or absent, another preamble follows as soon as the minimum preamble spacing has elapsed. Retries continue until a programmable number of preambles has been spent, and then the block raises a failure pulse. Mode 0 uses a lead of 7680 chips and a spacing and message delay of 3 slots. Mode 1 uses 12800 chips and 4 slots. Power ramping and signature choice are handled elsewhere.

Top module: `ra_slot_sequencer`

## Requirements
- R1: After a synchronous active-low reset, and at any time when no request has been accepted, the three output pulses stay low.
- R2: Every preamble starts on an uplink access-slot boundary. With the default parameters, that boundary is the chip 2560 chips after a downlink slot strobe, in both modes.
- R3: The first preamble of an attempt starts at the first uplink boundary chip that comes after the cycle in which the request was accepted.
- R4: In mode 0, the indicator is checked at the downlink strobe 7680 chips after a preamble. A retry preamble follows 15360 chips after the previous preamble, and the message starts 15360 chips after the acknowledged preamble.
- R5: In mode 1, the indicator is checked 12800 chips after a preamble. A retry follows 20480 chips after the previous preamble, and the message starts 20480 chips after the acknowledged preamble.
- R6: At the checked strobe, indicator-valid high with polarity high (positive) produces one message-start pulse. The attempt then ends with no further preamble.
- R7: A negative indicator (valid high, polarity low) or no indicator at the checked strobe causes a retry at the minimum spacing, as long as fewer preambles than the limit have been sent.
- R8: When the limit of preambles has been sent and the last one is not acknowledged, one failure pulse marks the chip of its checked strobe. A limit of 0 behaves as 1.
- R9: The mode bit and the preamble limit are captured when the request is accepted. Changing them later in the attempt has no effect.
- R10: A request raised while an attempt is in progress is ignored.
- R11: An indicator presented at any downlink strobe other than the checked one has no effect.
- R12: Each output pulse is one clock wide and appears one clock after its qualifying chip-enabled cycle. No two of the three pulses are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | High for one clock per chip |
| dl_slot_strobe | input | 1 | Start of a received downlink access slot, qualified by chip_en |
| timing_mode | input | 1 | Timing parameter set select, captured at request |
| max_preambles | input | PRE_W | Preamble limit per attempt, captured at request |
| access_req | input | 1 | Starts an attempt when the block is idle |
| ind_valid | input | 1 | An acquisition indicator is present |
| ind_positive | input | 1 | Indicator polarity, 1 = positive |
| preamble_start | output | 1 | Pulse: a preamble starts |
| message_start | output | 1 | Pulse: the message part starts |
| attempt_fail | output | 1 | Pulse: limit reached without a positive indicator |

## Verification
The embedded checks assume that chip_en is high for only one clock at a time, that dl_slot_strobe comes only together with chip_en, and that it comes exactly one slot length of chips after the previous strobe. They also assume that the lead time of each mode is shorter than that mode's spacing and message delay. The bench derives the strobe from its own running chip index, with a chip on every other clock, so the grid never drifts. It drives indicators only at strobe chips, at times computed from the expected preamble positions. Requests are raised only on clocks without a chip, so the first preamble chip is unambiguous.

// File: rtl/ra_slot_pkg.sv
// Shared types and helpers for the random-access slot sequencer.
// Assumes slot lengths of at least two chips.
package ra_slot_pkg;

    // Attempt sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_AI_WAIT,
        ST_RETRY,
        ST_MSG
    } ra_state_e;

    // Chip offset of the uplink boundary after a downlink strobe.
    function automatic int unsigned ul_offset(input int unsigned slot, input int unsigned lead);
        return (slot - (lead % slot)) % slot;
    endfunction

    // Larger of two values.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ra_phase_track.sv
// Tracks the chip phase inside the received downlink access slot and marks
// uplink slot boundaries for the captured timing mode.
// Assumes dl_slot_strobe arrives only with chip_en, every SLOT_CHIPS chips.
module ra_phase_track
    import ra_slot_pkg::*;
#(
    parameter int unsigned SLOT_CHIPS  = 5120,
    parameter int unsigned LEAD0_CHIPS = 7680,
    parameter int unsigned LEAD1_CHIPS = 12800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en,
    input  logic dl_slot_strobe,
    input  logic mode_q,
    output logic ul_edge,
    output logic dl_edge
);

    localparam int unsigned PH_W = $clog2(SLOT_CHIPS);
    localparam int unsigned OFS0 = ul_offset(SLOT_CHIPS, LEAD0_CHIPS);
    localparam int unsigned OFS1 = ul_offset(SLOT_CHIPS, LEAD1_CHIPS);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] cur_phase;
    logic [PH_W-1:0] ofs_sel;
    logic            synced_q;

    // Phase counter, restarted by every downlink strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            synced_q <= 1'b0;
        end else if (chip_en) begin
            if (dl_slot_strobe) begin
                phase_q  <= PH_W'(1);
                synced_q <= 1'b1;
            end else if (phase_q == PH_W'(SLOT_CHIPS - 1)) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + PH_W'(1);
            end
        end
    end

    // Boundary decode for the current chip.
    always_comb begin
        cur_phase = dl_slot_strobe ? '0 : phase_q;
        ofs_sel   = mode_q ? PH_W'(OFS1) : PH_W'(OFS0);
        ul_edge   = chip_en && (synced_q || dl_slot_strobe) && (cur_phase == ofs_sel);
        dl_edge   = chip_en && dl_slot_strobe;
    end

    // A strobe after sync must land exactly where the phase counter wrapped.
    assert_strobe_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && dl_slot_strobe && synced_q) |-> (phase_q == '0));

endmodule

// File: rtl/ra_chip_timer.sv
// Counts chips elapsed since the latest preamble; saturates at full scale.
// Assumes restart is raised only on a chip-enabled cycle.
module ra_chip_timer #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q
);

    // Elapsed-chip counter: 1 on the chip after a preamble, then +1 per chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= CNT_W'(1);
        end else if (chip_en && (cnt_q != '1)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // The count must advance by exactly one chip per enabled chip until full.
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !restart && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/ra_attempt_ctrl.sv
// Sequences one access attempt: arm, preamble, indicator check, retry or
// message, and failure after the preamble limit.
// Assumes each lead time is shorter than its spacing and message delay.
module ra_attempt_ctrl
    import ra_slot_pkg::*;
#(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned PRE_W   = 4,
    parameter int unsigned LEAD0_C = 7680,
    parameter int unsigned LEAD1_C = 12800,
    parameter int unsigned GAP0_C  = 15360,
    parameter int unsigned GAP1_C  = 20480,
    parameter int unsigned MSG0_C  = 15360,
    parameter int unsigned MSG1_C  = 20480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             ul_edge,
    input  logic             dl_edge,
    input  logic             req,
    input  logic             mode_in,
    input  logic [PRE_W-1:0] max_in,
    input  logic             ind_valid,
    input  logic             ind_positive,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             mode_q,
    output logic             pre_fire,
    output logic             msg_fire,
    output logic             fail_fire
);

    ra_state_e        state_q, state_d;
    logic [PRE_W-1:0] max_q;
    logic [PRE_W-1:0] sent_q;
    logic [CNT_W-1:0] lead_sel, gap_sel, msg_sel;
    logic             ai_due, ai_ack;

    // Per-mode chip targets.
    always_comb begin
        lead_sel = mode_q ? CNT_W'(LEAD1_C) : CNT_W'(LEAD0_C);
        gap_sel  = mode_q ? CNT_W'(GAP1_C)  : CNT_W'(GAP0_C);
        msg_sel  = mode_q ? CNT_W'(MSG1_C)  : CNT_W'(MSG0_C);
        ai_due   = chip_en && (cnt_q == lead_sel);
        ai_ack   = dl_edge && ind_valid && ind_positive;
    end

    // Next state and event decode.
    always_comb begin
        state_d   = state_q;
        pre_fire  = 1'b0;
        msg_fire  = 1'b0;
        fail_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (ul_edge) begin
                    pre_fire = 1'b1;
                    state_d  = ST_AI_WAIT;
                end
            end
            ST_AI_WAIT: begin
                if (ai_due) begin
                    if (ai_ack) begin
                        state_d = ST_MSG;
                    end else if (sent_q >= max_q) begin
                        fail_fire = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        state_d = ST_RETRY;
                    end
                end
            end
            ST_RETRY: begin
                if (chip_en && (cnt_q == gap_sel)) begin
                    pre_fire = 1'b1;
                    state_d  = ST_AI_WAIT;
                end
            end
            ST_MSG: begin
                if (chip_en && (cnt_q == msg_sel)) begin
                    msg_fire = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured configuration and preamble tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            max_q   <= '0;
            sent_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && req) begin
                mode_q <= mode_in;
                max_q  <= max_in;
                sent_q <= '0;
            end else if (pre_fire) begin
                sent_q <= sent_q + PRE_W'(1);
            end
        end
    end

    // Captured mode stays fixed across a running attempt.
    assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && $past(state_q != ST_IDLE)) |-> $stable(mode_q));

    // A request during an attempt leaves the captured configuration untouched.
    assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && req) |=> ($stable(max_q) && $stable(mode_q)));

    // Preambles sent never exceed the limit (0 counts as 1).
    assert_sent_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (sent_q <= ((max_q == '0) ? PRE_W'(1) : max_q)));

endmodule

// File: rtl/ra_slot_sequencer.sv
// Top of the random-access slot sequencer: phase tracker, elapsed-chip timer
// and attempt controller, with registered one-clock output pulses.
// Assumes a steady downlink strobe grid and one-clock chip enables.
module ra_slot_sequencer
    import ra_slot_pkg::*;
#(
    parameter int unsigned SLOT_CHIPS  = 5120,
    parameter int unsigned LEAD0_CHIPS = 7680,
    parameter int unsigned LEAD1_CHIPS = 12800,
    parameter int unsigned GAP0_SLOTS  = 3,
    parameter int unsigned GAP1_SLOTS  = 4,
    parameter int unsigned MSG0_SLOTS  = 3,
    parameter int unsigned MSG1_SLOTS  = 4,
    parameter int unsigned PRE_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             dl_slot_strobe,
    input  logic             timing_mode,
    input  logic [PRE_W-1:0] max_preambles,
    input  logic             access_req,
    input  logic             ind_valid,
    input  logic             ind_positive,
    output logic             preamble_start,
    output logic             message_start,
    output logic             attempt_fail
);

    localparam int unsigned GAP0_C = GAP0_SLOTS * SLOT_CHIPS;
    localparam int unsigned GAP1_C = GAP1_SLOTS * SLOT_CHIPS;
    localparam int unsigned MSG0_C = MSG0_SLOTS * SLOT_CHIPS;
    localparam int unsigned MSG1_C = MSG1_SLOTS * SLOT_CHIPS;
    localparam int unsigned SPAN   = max2(max2(max2(GAP0_C, GAP1_C), max2(MSG0_C, MSG1_C)),
                                          max2(LEAD0_CHIPS, LEAD1_CHIPS));
    localparam int unsigned CNT_W  = $clog2(SPAN + 2);

    logic             mode_q;
    logic             ul_edge, dl_edge;
    logic             pre_fire, msg_fire, fail_fire;
    logic [CNT_W-1:0] cnt_q;

    ra_phase_track #(
        .SLOT_CHIPS (SLOT_CHIPS),
        .LEAD0_CHIPS(LEAD0_CHIPS),
        .LEAD1_CHIPS(LEAD1_CHIPS)
    ) u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .chip_en       (chip_en),
        .dl_slot_strobe(dl_slot_strobe),
        .mode_q        (mode_q),
        .ul_edge       (ul_edge),
        .dl_edge       (dl_edge)
    );

    ra_chip_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .chip_en(chip_en),
        .restart(pre_fire),
        .cnt_q  (cnt_q)
    );

    ra_attempt_ctrl #(
        .CNT_W  (CNT_W),
        .PRE_W  (PRE_W),
        .LEAD0_C(LEAD0_CHIPS),
        .LEAD1_C(LEAD1_CHIPS),
        .GAP0_C (GAP0_C),
        .GAP1_C (GAP1_C),
        .MSG0_C (MSG0_C),
        .MSG1_C (MSG1_C)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_en     (chip_en),
        .ul_edge     (ul_edge),
        .dl_edge     (dl_edge),
        .req         (access_req),
        .mode_in     (timing_mode),
        .max_in      (max_preambles),
        .ind_valid   (ind_valid),
        .ind_positive(ind_positive),
        .cnt_q       (cnt_q),
        .mode_q      (mode_q),
        .pre_fire    (pre_fire),
        .msg_fire    (msg_fire),
        .fail_fire   (fail_fire)
    );

    // Output pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preamble_start <= 1'b0;
            message_start  <= 1'b0;
            attempt_fail   <= 1'b0;
        end else begin
            preamble_start <= pre_fire;
            message_start  <= msg_fire;
            attempt_fail   <= fail_fire;
        end
    end

    // Every preamble, first or retry, coincides with a tracked uplink boundary.
    assert_pre_on_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |-> ul_edge);

    // Output pulses are mutually exclusive.
    assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({preamble_start, message_start, attempt_fail}));

    // A preamble pulse lasts one clock.
    assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        preamble_start |=> !preamble_start);

endmodule

// File: tb/ra_slot_sequencer_bench.sv
`timescale 1ns/1ps
module ra_slot_sequencer_bench;

    localparam int SLOT   = 64;
    localparam int LEAD0  = 96;
    localparam int LEAD1  = 160;
    localparam int GAP0   = 3;
    localparam int GAP1   = 4;
    localparam int MSG0   = 3;
    localparam int MSG1   = 4;
    localparam int UL_OFS = 32;

    // Vector: {disturb, mode, neg, pos_at[3:0], maxp[3:0]}; pos_at 15 = never.
    localparam logic [10:0] VEC [0:7] = '{
        {1'b0, 1'b0, 1'b0, 4'd0,  4'd4},
        {1'b0, 1'b1, 1'b0, 4'd0,  4'd4},
        {1'b0, 1'b0, 1'b0, 4'd2,  4'd4},
        {1'b0, 1'b1, 1'b1, 4'd1,  4'd4},
        {1'b0, 1'b0, 1'b1, 4'd15, 4'd3},
        {1'b1, 1'b1, 1'b0, 4'd15, 4'd2},
        {1'b0, 1'b0, 1'b0, 4'd15, 4'd1},
        {1'b1, 1'b1, 1'b1, 4'd4,  4'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       dl_slot_strobe = 1'b0;
    logic       timing_mode = 1'b0;
    logic [3:0] max_preambles = 4'd1;
    logic       access_req = 1'b0;
    logic       ind_valid = 1'b0;
    logic       ind_positive = 1'b0;
    logic       preamble_start, message_start, attempt_fail;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int chip_now = -1;
    int pre_log [0:15];
    int n_pre = 0, n_msg = 0, n_fail = 0, msg_chip = 0, fail_chip = 0;
    int n_multi = 0, n_wide = 0;
    logic prev_pre = 1'b0, prev_msg = 1'b0, prev_fail = 1'b0;
    int ai_chip [0:15];
    bit ai_pos  [0:15];
    int n_ai = 0;

    always #2.5 clk = ~clk;

    ra_slot_sequencer #(
        .SLOT_CHIPS(SLOT), .LEAD0_CHIPS(LEAD0), .LEAD1_CHIPS(LEAD1),
        .GAP0_SLOTS(GAP0), .GAP1_SLOTS(GAP1), .MSG0_SLOTS(MSG0), .MSG1_SLOTS(MSG1),
        .PRE_W(4)
    ) u_ra_slot_sequencer (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .dl_slot_strobe(dl_slot_strobe),
        .timing_mode(timing_mode), .max_preambles(max_preambles), .access_req(access_req),
        .ind_valid(ind_valid), .ind_positive(ind_positive),
        .preamble_start(preamble_start), .message_start(message_start), .attempt_fail(attempt_fail)
    );

    // Chip grid driver and output logger: records pulses against the previous chip.
    always @(negedge clk) begin
        if (preamble_start) begin
            if (n_pre < 16) pre_log[n_pre] = chip_now;
            n_pre++;
        end
        if (message_start) begin msg_chip = chip_now; n_msg++; end
        if (attempt_fail)  begin fail_chip = chip_now; n_fail++; end
        if ((preamble_start + message_start + attempt_fail) > 1) n_multi++;
        if ((preamble_start && prev_pre) || (message_start && prev_msg) || (attempt_fail && prev_fail)) n_wide++;
        prev_pre = preamble_start; prev_msg = message_start; prev_fail = attempt_fail;
        cyc++;
        chip_en = (cyc % 2 == 0);
        if (chip_en) chip_now++;
        dl_slot_strobe = chip_en && (chip_now % SLOT == 0);
        ind_valid = 1'b0;
        ind_positive = 1'b0;
        if (dl_slot_strobe) begin
            for (int k = 0; k < n_ai; k++) begin
                if (ai_chip[k] == chip_now) begin
                    ind_valid = 1'b1;
                    ind_positive = ai_pos[k];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_pre = 0; n_msg = 0; n_fail = 0; n_multi = 0; n_wide = 0;
    endtask

    // Moves to just after a negedge at which no chip is driven.
    task automatic to_idle_cycle();
        @(negedge clk); #1;
        while (chip_en) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_req();
        to_idle_cycle();
        access_req = 1'b1;
        @(negedge clk); #1;
        access_req = 1'b0;
    endtask

    task automatic run_attempt(input bit m, input int maxp, input int pos_at,
                               input bit neg, input bit disturb, input bit spur);
        int eff, npre, lead, gap, msgd, p0, end_chip;
        int exp_pre [0:15];
        string tm;
        eff  = (maxp == 0) ? 1 : maxp;
        npre = (pos_at < eff) ? pos_at + 1 : eff;
        lead = m ? LEAD1 : LEAD0;
        gap  = (m ? GAP1 : GAP0) * SLOT;
        msgd = (m ? MSG1 : MSG0) * SLOT;
        tm   = m ? "R5" : "R4";
        clear_logs();
        n_ai = 0;
        to_idle_cycle();
        p0 = chip_now + 1;
        while (p0 % SLOT != UL_OFS) p0++;
        for (int k = 0; k < npre; k++) begin
            exp_pre[k] = p0 + k * gap;
            if (k == pos_at) begin
                ai_chip[n_ai] = exp_pre[k] + lead; ai_pos[n_ai] = 1'b1; n_ai++;
            end else if (neg) begin
                ai_chip[n_ai] = exp_pre[k] + lead; ai_pos[n_ai] = 1'b0; n_ai++;
            end
        end
        if (spur) begin
            ai_chip[n_ai] = p0 + lead - SLOT; ai_pos[n_ai] = 1'b1; n_ai++;
        end
        timing_mode = m;
        max_preambles = 4'(maxp);
        access_req = 1'b1;
        @(negedge clk); #1;
        access_req = 1'b0;
        if (disturb) begin
            timing_mode = !m;
            max_preambles = 4'd1;
            while (chip_now < p0 + 4) @(negedge clk);
            pulse_req();
        end
        end_chip = (pos_at < eff) ? exp_pre[npre-1] + msgd : exp_pre[npre-1] + lead;
        while (chip_now < end_chip + 2 * SLOT) @(negedge clk);
        #1;
        chk(n_pre == npre, disturb ? "R9/R10 preamble count" : "R7 preamble count", n_pre, npre);
        for (int k = 0; k < npre && k < n_pre; k++) begin
            chk(pre_log[k] == exp_pre[k], (k == 0) ? "R3 first preamble chip" : {tm, " retry chip"},
                pre_log[k], exp_pre[k]);
            chk(pre_log[k] % SLOT == UL_OFS, "R2 preamble on uplink boundary", pre_log[k] % SLOT, UL_OFS);
        end
        if (pos_at < eff) begin
            chk(n_msg == 1, "R6 message pulse count", n_msg, 1);
            chk(msg_chip == end_chip, {tm, " message chip"}, msg_chip, end_chip);
            chk(n_fail == 0, "R6 no failure", n_fail, 0);
        end else begin
            chk(n_fail == 1, spur ? "R11 failure despite stray indicator" : "R8 failure count", n_fail, 1);
            chk(fail_chip == end_chip, "R8 failure chip", fail_chip, end_chip);
            chk(n_msg == 0, "R8 no message", n_msg, 0);
        end
        chk(n_multi == 0, "R12 overlapping pulses", n_multi, 0);
        chk(n_wide == 0, "R12 pulse wider than one clock", n_wide, 0);
        n_ai = 0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!preamble_start && !message_start && !attempt_fail, "R1 outputs low after reset",
            preamble_start + message_start + attempt_fail, 0);
        clear_logs();
        repeat (8 * SLOT) @(negedge clk);
        #1;
        chk(n_pre + n_msg + n_fail == 0, "R1 no pulses without request", n_pre + n_msg + n_fail, 0);

        // Table walk.
        for (int v = 0; v < 8; v++) begin
            run_attempt(VEC[v][9], int'(VEC[v][3:0]), int'(VEC[v][7:4]), VEC[v][8], VEC[v][10], 1'b0);
        end

        // Stray positive indicator one slot before the checked strobe (R11).
        run_attempt(1'b0, 1, 15, 1'b0, 1'b0, 1'b1);
        run_attempt(1'b1, 2, 15, 1'b1, 1'b0, 1'b1);
        // Limit 0 acts as 1 (R8).
        run_attempt(1'b1, 0, 15, 1'b0, 1'b0, 1'b0);

        // Reset in the middle of an attempt silences the block (R1).
        clear_logs();
        timing_mode = 1'b0;
        max_preambles = 4'd3;
        pulse_req();
        while (n_pre == 0) @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        clear_logs();
        repeat (16 * SLOT) @(negedge clk);
        #1;
        chk(n_pre + n_msg + n_fail == 0, "R1 quiet after mid-attempt reset", n_pre + n_msg + n_fail, 0);
        run_attempt(1'b0, 2, 1, 1'b1, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule